// File: doc/BRIEF.md
# Set-Associative Data Address Translator

This block turns a virtual data address into a physical one through a small set-associative lookaside table. Each table slot is a pair of 32-bit words: a match word, holding the virtual tag and a valid bit, and a translate word, holding the physical page number, a cache-inhibit bit and four access-permission bits. A set is chosen from the address bits just above the page offset. Every way of that set is compared in parallel, and a hit supplies the physical page number. A request strobe starts a lookup. The registered result (physical address, cache-inhibit, hit, page fault, table miss, faulting address) appears one cycle later.

When translation is switched off, or the block is built without a table, the address passes through unchanged. Cache-inhibit then follows the top address bit. Software loads table slots through an indexed write port; the block never refills the table itself. A probe mode looks up an address without side effects: it raises no fault, and it emits no way-use pulse for the replacement tracker that sits beside this block.

Top module: `dtlb_xlate`

## Requirements
- R1: With `mmu_en` low, or with `MMU_PRESENT` = 0, `rsp_paddr` equals the request address. `rsp_ci` equals address bit 31 (set exactly when the address is at or above 0x80000000). `rsp_hit`, `rsp_pgfault`, `rsp_miss`, `rsp_fault_addr` and `way_hit` are all zero. This holds in probe mode as well.
- R2: The set index is (address >> `PAGE_BITS`) & (`SETS`-1).
- R3: A way hits when bit 0 (valid) of its match word is 1 and the match word equals the address once both are ANDed with ~(2^`PAGE_BITS` × `SETS` − 1). Bits below that mask in the match word do not affect the compare.
- R4: On a hit, `rsp_paddr` = (translate word with its low `PAGE_BITS` bits cleared) | (address & (2^`PAGE_BITS` − 1)), and `rsp_ci` = bit 0 of the translate word.
- R5: Translate word bits 1, 2, 3 and 4 grant user read, user write, supervisor read and supervisor write. On a non-probe hit whose needed bit (chosen by `req_super` and `req_write`) is 0, `rsp_pgfault` is 1 and `rsp_fault_addr` is the address; the translated address is still returned. Otherwise `rsp_fault_addr` is 0.
- R6: On a non-probe miss, `rsp_miss` is 1, `rsp_fault_addr` is the address, and `rsp_paddr`, `rsp_ci` and `rsp_hit` are 0. No slot is filled, so the same lookup misses again. A page fault and a miss are never raised together.
- R7: In probe mode, a miss or a failed permission check returns `rsp_paddr` = 0 and `rsp_ci` = 0 with no fault flag. Probe mode never produces a `way_hit` pulse. A probe hit that passes its check returns the R4 values.
- R8: Results are registered. `rsp_valid` is high in exactly the cycle after `req_valid`. The result outputs hold their values until the next request.
- R9: `cfg_we` writes `cfg_wdata` into way `cfg_way`, set `cfg_set`: the match word when `cfg_sel` = 0, the translate word when `cfg_sel` = 1. A lookup in the next cycle sees the new value.
- R10: When several ways hit, the lowest-numbered way supplies the result.
- R11: On every non-probe, translated hit (faulting or not), `way_hit` carries a one-hot pulse for the hitting way, for one cycle, together with `rsp_valid`.
- R12: After reset, every output is 0 and every slot is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup strobe |
| req_vaddr | input | AW | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_super | input | 1 | 1 = supervisor privilege |
| mmu_en | input | 1 | Translation enable |
| probe | input | 1 | Side-effect-free lookup |
| cfg_we | input | 1 | Table slot write strobe |
| cfg_way | input | WAY_IW | Way to write |
| cfg_set | input | SET_IW | Set to write |
| cfg_sel | input | 1 | 0 = match word, 1 = translate word |
| cfg_wdata | input | AW | Word to write |
| rsp_valid | output | 1 | Result strobe |
| rsp_paddr | output | AW | Physical address |
| rsp_ci | output | 1 | Cache-inhibit |
| rsp_hit | output | 1 | A way matched |
| rsp_pgfault | output | 1 | Permission fault |
| rsp_miss | output | 1 | Table miss fault |
| rsp_fault_addr | output | AW | Address that faulted, else 0 |
| way_hit | output | WAYS | One-hot way-use pulse |

## Verification
The assertions assume that the write port never selects a way at or above `WAYS`, and that `req_valid` is a single-cycle strobe whose companion inputs are stable in that cycle. The bench drives every input on the falling clock edge, writes only legal way and set numbers, and sends each request as a one-cycle pulse. It sweeps every set, every way, all sixteen permission codes with both privilege levels, both directions and both probe settings, along with addresses on either side of the cache-inhibit boundary. Expected values come from the bench's own copy of the words it wrote.

// File: rtl/dtlb_pkg.sv
// Package: shared field positions for the data translator.
// Assumes 32-bit or wider table words; the low bits of a word lie below
// the page offset, so the flags there never overlap an address field.
package dtlb_pkg;
    localparam int MT_VALID = 0;   // match word: slot valid
    localparam int XL_CI    = 0;   // translate word: cache inhibit
    localparam int XL_UR    = 1;   // user read enable
    localparam int XL_UW    = 2;   // user write enable
    localparam int XL_SR    = 3;   // supervisor read enable
    localparam int XL_SW    = 4;   // supervisor write enable
endpackage

// File: rtl/dtlb_store.sv
// Module: table storage. Holds WAYS x SETS match and translate words,
// written through an indexed port and read for one set across all ways.
// Assumes cfg_way < WAYS; out-of-range writes are dropped.
module dtlb_store #(
    parameter int AW     = 32,
    parameter int WAYS   = 2,
    parameter int SETS   = 4,
    parameter int SET_IW = 2,
    parameter int WAY_IW = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [WAY_IW-1:0]        cfg_way,
    input  logic [SET_IW-1:0]        cfg_set,
    input  logic                     cfg_sel,
    input  logic [AW-1:0]            cfg_wdata,
    input  logic [SET_IW-1:0]        rd_set,
    output logic [WAYS-1:0][AW-1:0]  rd_match,
    output logic [WAYS-1:0][AW-1:0]  rd_xlate
);
    logic [AW-1:0] mt [WAYS][SETS];
    logic [AW-1:0] xt [WAYS][SETS];

    // Slot write port; reset clears every word, so every slot is invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++)
                for (int s = 0; s < SETS; s++) begin
                    mt[w][s] <= '0;
                    xt[w][s] <= '0;
                end
        end else if (cfg_we && int'(cfg_way) < WAYS && int'(cfg_set) < SETS) begin
            if (cfg_sel) xt[cfg_way][cfg_set] <= cfg_wdata;
            else         mt[cfg_way][cfg_set] <= cfg_wdata;
        end
    end

    // Read every way of the addressed set in parallel.
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_match[w] = mt[w][rd_set];
        assign rd_xlate[w] = xt[w][rd_set];
    end
endmodule

// File: rtl/dtlb_match.sv
// Module: per-way tag compare and lowest-way priority select.
// Assumes rd_match holds the words of the set chosen by vaddr.
module dtlb_match #(
    parameter int AW        = 32,
    parameter int WAYS      = 2,
    parameter int WAY_IW    = 1,
    parameter int PAGE_BITS = 13,
    parameter int SET_BITS  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            vaddr,
    input  logic [WAYS-1:0][AW-1:0]  rd_match,
    output logic [WAYS-1:0]          hit_vec,
    output logic [WAY_IW-1:0]        sel_way,
    output logic                     any_hit
);
    import dtlb_pkg::*;
    localparam logic [AW-1:0] TAG_MASK = ~AW'((64'd1 << (PAGE_BITS + SET_BITS)) - 1);

    // Compare each way's tag under the mask and qualify it with valid.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = rd_match[w][MT_VALID] &&
                            ((rd_match[w] & TAG_MASK) == (vaddr & TAG_MASK));
    end

    // Pick the lowest-numbered hitting way.
    always_comb begin
        sel_way = '0;
        any_hit = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                sel_way = WAY_IW'(w);
                any_hit = 1'b1;
            end
        end
    end

    logic [WAYS-1:0] below_sel;
    // Ways ranked ahead of the chosen one, for the priority check.
    always_comb begin
        for (int w = 0; w < WAYS; w++) below_sel[w] = (w < int'(sel_way));
    end

    p_lowest_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (hit_vec[sel_way] && ((hit_vec & below_sel) == '0)));
endmodule

// File: rtl/dtlb_perm.sv
// Module: access permission check by privilege and direction.
// Assumes perm = {sup write, sup read, user write, user read}.
module dtlb_perm (
    input  logic [3:0] perm,
    input  logic       is_write,
    input  logic       is_super,
    output logic       ok
);
    // Select the one enable bit that governs this access.
    always_comb begin
        case ({is_super, is_write})
            2'b00:   ok = perm[0];
            2'b01:   ok = perm[1];
            2'b10:   ok = perm[2];
            default: ok = perm[3];
        endcase
    end
endmodule

// File: rtl/dtlb_xlate.sv
// Module: data address translator top. Looks up the set in the table,
// checks permissions and registers the result one cycle after req_valid.
// Assumes SETS is a power of two no greater than 128, and WAYS is 1..4.
module dtlb_xlate #(
    parameter int AW          = 32,
    parameter int WAYS        = 2,
    parameter int SETS        = 4,
    parameter int PAGE_BITS   = 13,
    parameter bit MMU_PRESENT = 1'b1,
    localparam int SET_BITS   = $clog2(SETS),
    localparam int SET_IW     = (SET_BITS > 0) ? SET_BITS : 1,
    localparam int WAY_IW     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_vaddr,
    input  logic              req_write,
    input  logic              req_super,
    input  logic              mmu_en,
    input  logic              probe,
    input  logic              cfg_we,
    input  logic [WAY_IW-1:0] cfg_way,
    input  logic [SET_IW-1:0] cfg_set,
    input  logic              cfg_sel,
    input  logic [AW-1:0]     cfg_wdata,
    output logic              rsp_valid,
    output logic [AW-1:0]     rsp_paddr,
    output logic              rsp_ci,
    output logic              rsp_hit,
    output logic              rsp_pgfault,
    output logic              rsp_miss,
    output logic [AW-1:0]     rsp_fault_addr,
    output logic [WAYS-1:0]   way_hit
);
    import dtlb_pkg::*;
    localparam logic [AW-1:0] OFF_MASK = AW'((64'd1 << PAGE_BITS) - 1);

    logic [SET_IW-1:0]       set_idx;
    logic [WAYS-1:0][AW-1:0] rd_match, rd_xlate;
    logic [WAYS-1:0]         hit_vec;
    logic [WAY_IW-1:0]       sel_way;
    logic                    any_hit, perm_ok, bypass;
    logic [AW-1:0]           xw, xpa;
    logic [AW-1:0]           n_pa, n_fa;
    logic                    n_ci, n_hit, n_pf, n_miss;
    logic [WAYS-1:0]         n_wh;

    // Bypass when disabled or built without a table; choose the set.
    always_comb begin
        bypass  = !mmu_en || !MMU_PRESENT;
        set_idx = SET_IW'((req_vaddr >> PAGE_BITS) & AW'(SETS - 1));
    end

    dtlb_store #(.AW(AW), .WAYS(WAYS), .SETS(SETS), .SET_IW(SET_IW), .WAY_IW(WAY_IW)) u_store (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_way(cfg_way), .cfg_set(cfg_set),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rd_set(set_idx),
        .rd_match(rd_match), .rd_xlate(rd_xlate));

    dtlb_match #(.AW(AW), .WAYS(WAYS), .WAY_IW(WAY_IW), .PAGE_BITS(PAGE_BITS),
                 .SET_BITS(SET_BITS)) u_match (
        .clk(clk), .rst_n(rst_n), .vaddr(req_vaddr), .rd_match(rd_match),
        .hit_vec(hit_vec), .sel_way(sel_way), .any_hit(any_hit));

    // Chosen translate word and the address it produces.
    always_comb begin
        xw  = rd_xlate[sel_way];
        xpa = (xw & ~OFF_MASK) | (req_vaddr & OFF_MASK);
    end

    dtlb_perm u_perm (.perm(xw[XL_SW:XL_UR]), .is_write(req_write),
                      .is_super(req_super), .ok(perm_ok));

    // Build the next result from the mode, the hit and the permission check.
    always_comb begin
        n_pa = '0; n_ci = 1'b0; n_hit = 1'b0; n_pf = 1'b0;
        n_miss = 1'b0; n_fa = '0; n_wh = '0;
        if (bypass) begin
            n_pa = req_vaddr;
            n_ci = req_vaddr[AW-1];
        end else if (any_hit) begin
            n_hit = 1'b1;
            if (probe) begin
                if (perm_ok) begin
                    n_pa = xpa;
                    n_ci = xw[XL_CI];
                end
            end else begin
                n_pa = xpa;
                n_ci = xw[XL_CI];
                n_pf = !perm_ok;
                n_fa = perm_ok ? '0 : req_vaddr;
                n_wh[sel_way] = 1'b1;
            end
        end else if (!probe) begin
            n_miss = 1'b1;
            n_fa   = req_vaddr;
        end
    end

    // Result register: loads on a request, way pulse lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0; rsp_paddr <= '0; rsp_ci <= 1'b0; rsp_hit <= 1'b0;
            rsp_pgfault <= 1'b0; rsp_miss <= 1'b0; rsp_fault_addr <= '0; way_hit <= '0;
        end else begin
            rsp_valid <= req_valid;
            way_hit   <= req_valid ? n_wh : '0;
            if (req_valid) begin
                rsp_paddr <= n_pa; rsp_ci <= n_ci; rsp_hit <= n_hit;
                rsp_pgfault <= n_pf; rsp_miss <= n_miss; rsp_fault_addr <= n_fa;
            end
        end
    end

    p_bypass_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bypass) |=> (rsp_paddr == $past(req_vaddr) &&
                                   rsp_ci == $past(req_vaddr[AW-1]) && !rsp_hit));
    p_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_miss && rsp_pgfault));
    p_probe_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && probe) |=> (!rsp_miss && !rsp_pgfault && way_hit == '0));
    p_rsp_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_rsp_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_way_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit) && (way_hit == '0 || (rsp_valid && rsp_hit)));
endmodule

// File: tb/tb_dtlb_xlate.sv
module tb_dtlb_xlate;
    localparam int PB = 13, NS = 4, NW = 2;
    localparam logic [31:0] OFFM = 32'h0000_1FFF;
    localparam logic [31:0] TAGM = ~32'h0000_7FFF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_super = 0, mmu_en = 0, probe = 0;
    logic [31:0] req_vaddr = '0, cfg_wdata = '0;
    logic cfg_we = 0, cfg_sel = 0;
    logic [0:0] cfg_way = '0;
    logic [1:0] cfg_set = '0;
    logic rsp_valid, rsp_ci, rsp_hit, rsp_pgfault, rsp_miss;
    logic [31:0] rsp_paddr, rsp_fault_addr;
    logic [1:0] way_hit;

    int n_chk = 0, n_fail = 0;
    logic [31:0] bm [NW][NS];
    logic [31:0] bt [NW][NS];

    always #5 clk = ~clk;

    dtlb_xlate dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_super(req_super), .mmu_en(mmu_en), .probe(probe),
        .cfg_we(cfg_we), .cfg_way(cfg_way), .cfg_set(cfg_set), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_ci(rsp_ci),
        .rsp_hit(rsp_hit), .rsp_pgfault(rsp_pgfault), .rsp_miss(rsp_miss),
        .rsp_fault_addr(rsp_fault_addr), .way_hit(way_hit));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_slot(input int w, input int s, input bit sel, input logic [31:0] d);
        cfg_we = 1; cfg_way = w[0:0]; cfg_set = s[1:0]; cfg_sel = sel; cfg_wdata = d;
        if (sel) bt[w][s] = d; else bm[w][s] = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // Request, then sample the registered result one edge later.
    task automatic lookup(input string tag, input logic [31:0] va, input bit wr,
                          input bit sup, input bit en, input bit prb);
        logic [31:0] e_pa, e_fa, t;
        logic e_ci, e_hit, e_pf, e_miss, ok;
        logic [1:0] e_wh;
        int hw;
        e_pa = 0; e_fa = 0; e_ci = 0; e_hit = 0; e_pf = 0; e_miss = 0; e_wh = 0; hw = -1;
        if (!en) begin
            e_pa = va; e_ci = va[31];
        end else begin
            for (int w = NW - 1; w >= 0; w--)
                if (bm[w][(va >> PB) & (NS - 1)][0] &&
                    (bm[w][(va >> PB) & (NS - 1)] & TAGM) == (va & TAGM)) hw = w;
            if (hw >= 0) begin
                t = bt[hw][(va >> PB) & (NS - 1)];
                ok = sup ? (wr ? t[4] : t[3]) : (wr ? t[2] : t[1]);
                e_hit = 1;
                if (!prb || ok) begin e_pa = (t & ~OFFM) | (va & OFFM); e_ci = t[0]; end
                if (!prb) begin
                    e_pf = !ok; e_fa = ok ? 0 : va; e_wh = 2'(1 << hw);
                end
            end else if (!prb) begin
                e_miss = 1; e_fa = va;
            end
        end
        req_valid = 1; req_vaddr = va; req_write = wr; req_super = sup; mmu_en = en; probe = prb;
        @(negedge clk);
        req_valid = 0;
        chk({tag, " R8 valid"}, 32'(rsp_valid), 1);
        chk({tag, " paddr"}, rsp_paddr, e_pa);
        chk({tag, " ci"}, 32'(rsp_ci), 32'(e_ci));
        chk({tag, " hit"}, 32'(rsp_hit), 32'(e_hit));
        chk({tag, " pgfault"}, 32'(rsp_pgfault), 32'(e_pf));
        chk({tag, " miss"}, 32'(rsp_miss), 32'(e_miss));
        chk({tag, " fault_addr"}, rsp_fault_addr, e_fa);
        chk({tag, " R11 way_hit"}, 32'(way_hit), 32'(e_wh));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int w = 0; w < NW; w++) for (int s = 0; s < NS; s++) begin bm[w][s] = 0; bt[w][s] = 0; end
        repeat (3) @(negedge clk);
        // R12: reset state of the outputs
        chk("R12 rsp_valid", 32'(rsp_valid), 0);
        chk("R12 paddr", rsp_paddr, 0);
        chk("R12 way_hit", 32'(way_hit), 0);
        rst_n = 1;
        @(negedge clk);
        lookup("R12 empty table", 32'h0000_1234, 0, 1, 1, 0);

        // R1: bypass sweep, both probe settings, across the inhibit boundary
        lookup("R1 bypass lo", 32'h7FFF_FFFF, 0, 0, 0, 0);
        lookup("R1 bypass hi", 32'h8000_0000, 1, 1, 0, 0);
        for (int i = 0; i < 16; i++) begin
            lookup("R1 bypass sweep", 32'h1111_1111 * i, i[0], i[1], 0, i[2]);
        end

        // R9/R2/R3/R4: load every slot (junk low bits in match words), sweep
        for (int w = 0; w < NW; w++) for (int s = 0; s < NS; s++) begin
            wr_slot(w, s, 0, (32'h1000_0000 * (w + 1)) | 32'(s << PB) | 32'h0000_60F1);
            wr_slot(w, s, 1, 32'h4000_0000 + 32'h0100_0000 * w + 32'(s << PB) + 32'h1E + 32'(s & 1));
        end
        for (int w = 0; w < NW; w++) for (int s = 0; s < NS; s++) for (int k = 0; k < 4; k++) begin
            lookup("R2 R3 R4 hit sweep",
                   (32'h1000_0000 * (w + 1)) | 32'(s << PB) | (32'h0000_0777 * k),
                   k[0], k[1], 1, 0);
        end
        // R3: same set, different tag misses
        lookup("R3 tag mismatch", 32'h3000_2000, 0, 1, 1, 0);

        // R5 / R7: all permission codes for way0 set1
        for (int p = 0; p < 16; p++) begin
            wr_slot(0, 1, 1, 32'h5550_0000 | 32'(p << 1));
            for (int m = 0; m < 8; m++)
                lookup("R5 R7 perm sweep", 32'h1000_2ABC, m[0], m[1], 1, m[2]);
        end

        // R6: miss, and it stays a miss (no refill); probe miss quiet (R7)
        lookup("R6 miss", 32'h7700_4010, 1, 0, 1, 0);
        lookup("R6 miss again", 32'h7700_4010, 0, 0, 1, 0);
        lookup("R7 probe miss", 32'h7700_4010, 0, 0, 1, 1);

        // R10: duplicate tag in set 2, lowest way wins; invalidate way0 -> way1
        wr_slot(1, 2, 0, 32'h1000_4001);
        lookup("R10 lowest way", 32'h1000_4123, 0, 1, 1, 0);
        wr_slot(0, 2, 0, 32'h1000_4000);
        lookup("R9 R10 after invalidate", 32'h1000_4123, 0, 1, 1, 0);

        // R8: result strobe and way pulse last one cycle; result holds
        @(negedge clk);
        chk("R8 valid drops", 32'(rsp_valid), 0);
        chk("R11 pulse drops", 32'(way_hit), 0);
        chk("R8 paddr holds", rsp_paddr, 32'h4100_4123);
        finish_run();
    end
endmodule